// File: doc/BRIEF.md
# Three-Color Linear CCD Drive Clock Sequencer

This block generates every digital drive clock needed to read one line from a three-color linear CCD that has an odd and an even output per color. Running from a single system clock, it produces two transfer-gate pulses, a pair of complementary shift phases, a last-stage shift phase, a reset-gate pulse and a clamp pulse. All pulse widths and gaps are taken from configuration inputs and are counted in system-clock cycles.

A line begins when a start request arrives while the block is idle. First comes a transfer period. Shift phase A is raised, then the two transfer gates are pulsed one after the other, then a settling gap follows. The reset-gate and clamp clocks stay low for the whole of this period. Next comes readout, which clocks a fixed number of pixels per channel. Each pixel is one full shift-phase period. A clamp-mode input selects one of two clamp behaviours: a clamp pulse for every pixel, or a clamp held high only across the optical-black span. The block also reports its progress through a busy flag, a pixel index and a region code.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, and whenever the block is idle: both transfer gates, shift_a, shift_last, reset_gate and clamp_pulse are low, shift_b is high, line_busy is low, and pixel_index and region are 0.
- R2: A line_start seen while idle raises line_busy and shift_a at the next clock edge. shift_a is then high for exactly cfg_lead cycles before xfer_gate_a rises.
- R3: xfer_gate_a is high for cfg_tg_width cycles. It is then followed by cfg_tg_gap low cycles, after which xfer_gate_b is high for cfg_tg_width cycles. The two gates are never high together.
- R4: From the rise of line_busy until pixel clocking begins, shift_a stays high and reset_gate, clamp_pulse and shift_last stay low.
- R5: The first fall of shift_a after xfer_gate_b falls comes exactly cfg_post cycles after the fall of xfer_gate_b. That fall starts pixel 0.
- R6: During readout, each pixel consists of cfg_half cycles with shift_a low followed by cfg_half cycles with shift_a high. shift_b is always the complement of shift_a. shift_last equals shift_b during readout and is low at all other times.
- R7: reset_gate is high for exactly one cycle, the first cycle of each pixel. It pulses N_DUMMY+N_OB+N_INV_LEAD+N_VALID+N_INV_TRAIL times per line.
- R8: When clamp_mode is 0 (per-pixel clamp), clamp_pulse is high for one cycle per pixel, in the cycle right after reset_gate.
- R9: When clamp_mode is 1 (span clamp), clamp_pulse is high without a break across every cycle of the optical-black pixels and is low everywhere else.
- R10: pixel_index counts 0,1,2,… from pixel to pixel. region reads 0 for the N_DUMMY dummy pixels, 1 for the N_OB optical-black pixels, 2 for the N_INV_LEAD invalid pixels, 3 for the N_VALID valid pixels, and 2 again for the N_INV_TRAIL trailing invalid pixels.
- R11: A line_start that arrives while line_busy is high is ignored. The line ends at its normal time and no second line follows.
- R12: A value of 0 in cfg_lead, cfg_tg_width, cfg_tg_gap or cfg_post counts as 1, and a cfg_half below 2 counts as 2. line_busy falls right after the last cycle of the final pixel, so the line lasts lead+2·width+gap+post+2·half·pixels cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Request to begin a line |
| clamp_mode | input | 1 | 0 = per-pixel clamp, 1 = optical-black span clamp |
| cfg_lead | input | CNT_W | Cycles shift_a is high before the first gate |
| cfg_tg_width | input | CNT_W | High width of each transfer gate |
| cfg_tg_gap | input | CNT_W | Low cycles between the two gates |
| cfg_post | input | CNT_W | Cycles from the second gate's fall to pixel 0 |
| cfg_half | input | CNT_W | Cycles per shift half-period |
| xfer_gate_a | output | 1 | First transfer-gate pulse |
| xfer_gate_b | output | 1 | Second transfer-gate pulse |
| shift_a | output | 1 | Shift phase A |
| shift_b | output | 1 | Shift phase B, complement of A |
| shift_last | output | 1 | Last-stage shift phase |
| reset_gate | output | 1 | Output-node reset pulse |
| clamp_pulse | output | 1 | Reset-level clamp pulse |
| line_busy | output | 1 | High from the accepted start to the end of the line |
| pixel_index | output | IDX_W | Pixel number within the line |
| region | output | 2 | Region code of the current pixel |

## Verification
The bench builds the block with N_VALID reduced to 24 and keeps the other region counts at their defaults, giving 91 pixels per line. At that size, complete lines in both clamp modes take only a few hundred cycles, so every region boundary, the trailing invalid span and the end of line are each seen several times. The timing fields cover values near the nominal settings at 10 ns, all-zero fields and small odd values. This reaches the clamped-minimum paths and half-periods of 2, 3 and 4 cycles.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_LEAD,
        XS_TG1,
        XS_GAP,
        XS_TG2,
        XS_POST,
        XS_READ
    } xfer_state_e;

    typedef enum logic [1:0] {
        RG_DUMMY = 2'd0,
        RG_DARK  = 2'd1,
        RG_SPARE = 2'd2,
        RG_LIVE  = 2'd3
    } region_e;

endpackage

// File: rtl/ccd_region_map.sv
module ccd_region_map
    import ccd_tg_pkg::*;
#(
    parameter int IDX_W      = 12,
    parameter int N_DUMMY    = 13,
    parameter int N_OB       = 48,
    parameter int N_INV_LEAD = 3,
    parameter int N_VALID    = 3750
) (
    input  logic [IDX_W-1:0] idx,
    output region_e          region
);
    localparam int B_DARK  = N_DUMMY;
    localparam int B_SPARE = B_DARK + N_OB;
    localparam int B_LIVE  = B_SPARE + N_INV_LEAD;
    localparam int B_TAIL  = B_LIVE + N_VALID;

    always_comb begin
        if (int'(idx) < B_DARK)       region = RG_DUMMY;
        else if (int'(idx) < B_SPARE) region = RG_DARK;
        else if (int'(idx) < B_LIVE)  region = RG_SPARE;
        else if (int'(idx) < B_TAIL)  region = RG_LIVE;
        else                          region = RG_SPARE;
    end
endmodule

// File: rtl/ccd_xfer_seq.sv
module ccd_xfer_seq
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [CNT_W-1:0] cfg_lead,
    input  logic [CNT_W-1:0] cfg_tg_width,
    input  logic [CNT_W-1:0] cfg_tg_gap,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic             read_done,
    output logic             gate_a,
    output logic             gate_b,
    output logic             hold_a,
    output logic             busy,
    output logic             read_go
);
    typedef struct packed {
        xfer_state_e      st;
        logic [CNT_W-1:0] cnt;
    } xs_t;

    xs_t  s_d, s_q;
    logic last;

    function automatic logic [CNT_W-1:0] load(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign last = (s_q.cnt == '0);

    always_comb begin
        s_d     = s_q;
        read_go = 1'b0;
        if (!last) s_d.cnt = s_q.cnt - 1'b1;
        unique case (s_q.st)
            XS_IDLE: if (line_start) begin
                s_d.st  = XS_LEAD;
                s_d.cnt = load(cfg_lead);
            end
            XS_LEAD: if (last) begin
                s_d.st  = XS_TG1;
                s_d.cnt = load(cfg_tg_width);
            end
            XS_TG1: if (last) begin
                s_d.st  = XS_GAP;
                s_d.cnt = load(cfg_tg_gap);
            end
            XS_GAP: if (last) begin
                s_d.st  = XS_TG2;
                s_d.cnt = load(cfg_tg_width);
            end
            XS_TG2: if (last) begin
                s_d.st  = XS_POST;
                s_d.cnt = load(cfg_post);
            end
            XS_POST: if (last) begin
                s_d.st  = XS_READ;
                read_go = 1'b1;
            end
            XS_READ: if (read_done) s_d.st = XS_IDLE;
            default: s_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= XS_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_a = (s_q.st == XS_TG1);
    assign gate_b = (s_q.st == XS_TG2);
    assign hold_a = (s_q.st != XS_IDLE) && (s_q.st != XS_READ);
    assign busy   = (s_q.st != XS_IDLE);

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != XS_IDLE && s_q.st != XS_LEAD) |=> (s_q.st != XS_LEAD)); // R11
    AST_GATE_B_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_b) |-> ($past(s_q.st) == XS_GAP)); // R3
endmodule

// File: rtl/ccd_pix_seq.sv
module ccd_pix_seq
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TOTAL = 3817,
    parameter int IDX_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             line_mode,
    input  logic [CNT_W-1:0] cfg_half,
    input  region_e          region,
    output logic             active,
    output logic             phase_a,
    output logic             last_stage,
    output logic             rst_pulse,
    output logic             clamp,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    typedef struct packed {
        logic             active;
        logic             tog;
        logic [CNT_W-1:0] hcnt;
        logic [IDX_W-1:0] idx;
    } ps_t;

    ps_t              s_d, s_q;
    logic [CNT_W-1:0] half_m1;
    logic             hlast;

    assign half_m1 = (cfg_half < CNT_W'(2)) ? CNT_W'(1) : cfg_half - 1'b1;
    assign hlast   = (s_q.hcnt >= half_m1);

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.tog    = 1'b0;
                s_d.hcnt   = '0;
                s_d.idx    = '0;
            end
        end else if (hlast) begin
            s_d.hcnt = '0;
            s_d.tog  = ~s_q.tog;
            if (s_q.tog) begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.active = 1'b0;
                    s_d.idx    = '0;
                    done       = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end else begin
            s_d.hcnt = s_q.hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.active <= 1'b0;
            s_q.tog    <= 1'b0;
            s_q.hcnt   <= '0;
            s_q.idx    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active     = s_q.active;
    assign idx        = s_q.idx;
    assign phase_a    = s_q.active & s_q.tog;
    assign last_stage = s_q.active & ~s_q.tog;
    assign rst_pulse  = s_q.active & ~s_q.tog & (s_q.hcnt == '0);
    assign clamp      = line_mode ? (s_q.active && region == RG_DARK)
                                  : (s_q.active & ~s_q.tog & (s_q.hcnt == CNT_W'(1)));

    AST_BIT_CLAMP_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_mode && clamp) |-> $past(rst_pulse)); // R8
    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse); // R7
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx <= LAST_IDX)); // R10
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && idx != $past(idx)) |-> (idx == $past(idx) + 1'b1)); // R10
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_tg_pkg::*;
#(
    parameter  int CNT_W       = 12,
    parameter  int N_DUMMY     = 13,
    parameter  int N_OB        = 48,
    parameter  int N_INV_LEAD  = 3,
    parameter  int N_VALID     = 3750,
    parameter  int N_INV_TRAIL = 3,
    localparam int TOTAL       = N_DUMMY + N_OB + N_INV_LEAD + N_VALID + N_INV_TRAIL,
    localparam int IDX_W       = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             clamp_mode,
    input  logic [CNT_W-1:0] cfg_lead,
    input  logic [CNT_W-1:0] cfg_tg_width,
    input  logic [CNT_W-1:0] cfg_tg_gap,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic [CNT_W-1:0] cfg_half,
    output logic             xfer_gate_a,
    output logic             xfer_gate_b,
    output logic             shift_a,
    output logic             shift_b,
    output logic             shift_last,
    output logic             reset_gate,
    output logic             clamp_pulse,
    output logic             line_busy,
    output logic [IDX_W-1:0] pixel_index,
    output logic [1:0]       region
);
    logic    hold_a, read_go, read_done, pix_active, pix_phase_a;
    region_e region_w;

    ccd_xfer_seq #(.CNT_W(CNT_W)) xfer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .cfg_lead     (cfg_lead),
        .cfg_tg_width (cfg_tg_width),
        .cfg_tg_gap   (cfg_tg_gap),
        .cfg_post     (cfg_post),
        .read_done    (read_done),
        .gate_a       (xfer_gate_a),
        .gate_b       (xfer_gate_b),
        .hold_a       (hold_a),
        .busy         (line_busy),
        .read_go      (read_go)
    );

    ccd_pix_seq #(.CNT_W(CNT_W), .TOTAL(TOTAL), .IDX_W(IDX_W)) pix_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (read_go),
        .line_mode  (clamp_mode),
        .cfg_half   (cfg_half),
        .region     (region_w),
        .active     (pix_active),
        .phase_a    (pix_phase_a),
        .last_stage (shift_last),
        .rst_pulse  (reset_gate),
        .clamp      (clamp_pulse),
        .done       (read_done),
        .idx        (pixel_index)
    );

    ccd_region_map #(
        .IDX_W(IDX_W), .N_DUMMY(N_DUMMY), .N_OB(N_OB),
        .N_INV_LEAD(N_INV_LEAD), .N_VALID(N_VALID)
    ) map_i (
        .idx    (pixel_index),
        .region (region_w)
    );

    assign shift_a = hold_a | pix_phase_a;
    assign shift_b = ~shift_a;
    assign region  = region_w;

    AST_XFER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold_a |-> !(reset_gate || clamp_pulse || shift_last)); // R4
    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_gate_a && xfer_gate_b)); // R3
    AST_READ_FOLLOWS_POST: assert property (@(posedge clk) disable iff (!rst_n)
        read_go |=> pix_active); // R5
    AST_SPAN_CLAMP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_mode && clamp_pulse) |-> (region_w == RG_DARK)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !line_busy |-> !(shift_a || reset_gate || clamp_pulse || xfer_gate_a || xfer_gate_b)); // R1
endmodule

// File: tb/ccd_line_timer_tb_top.sv
module ccd_line_timer_tb_top;
    localparam int CNT_W   = 12;
    localparam int N_DUM   = 13;
    localparam int N_OB    = 48;
    localparam int N_INVL  = 3;
    localparam int N_VAL   = 24;
    localparam int N_INVT  = 3;
    localparam int TOTAL   = N_DUM + N_OB + N_INVL + N_VAL + N_INVT;
    localparam int IDX_W   = $clog2(TOTAL);
    localparam int NVEC    = 5;
    // lead, tg_width, tg_gap, post, half, clamp_mode, poke_while_busy
    localparam int VEC [NVEC][7] = '{
        '{20, 110, 20, 160, 2, 0, 0},
        '{10, 100,  5, 150, 3, 1, 0},
        '{ 0,   0,  0,   0, 0, 0, 0},
        '{12, 105,  8, 155, 2, 1, 1},
        '{ 3,   4,  2,   5, 4, 0, 0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_start = 1'b0;
    logic             clamp_mode = 1'b0;
    logic [CNT_W-1:0] cfg_lead = '0, cfg_tg_width = '0, cfg_tg_gap = '0, cfg_post = '0, cfg_half = '0;
    logic             xfer_gate_a, xfer_gate_b, shift_a, shift_b, shift_last;
    logic             reset_gate, clamp_pulse, line_busy;
    logic [IDX_W-1:0] pixel_index;
    logic [1:0]       region;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ccd_line_timer #(
        .CNT_W(CNT_W), .N_DUMMY(N_DUM), .N_OB(N_OB),
        .N_INV_LEAD(N_INVL), .N_VALID(N_VAL), .N_INV_TRAIL(N_INVT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .clamp_mode(clamp_mode),
        .cfg_lead(cfg_lead), .cfg_tg_width(cfg_tg_width), .cfg_tg_gap(cfg_tg_gap),
        .cfg_post(cfg_post), .cfg_half(cfg_half),
        .xfer_gate_a(xfer_gate_a), .xfer_gate_b(xfer_gate_b), .shift_a(shift_a),
        .shift_b(shift_b), .shift_last(shift_last), .reset_gate(reset_gate),
        .clamp_pulse(clamp_pulse), .line_busy(line_busy), .pixel_index(pixel_index),
        .region(region)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_region(input int p);
        if (p < N_DUM) return 0;
        if (p < N_DUM + N_OB) return 1;
        if (p < N_DUM + N_OB + N_INVL) return 2;
        if (p < N_DUM + N_OB + N_INVL + N_VAL) return 3;
        return 2;
    endfunction

    function automatic bit idle_ok();
        return !xfer_gate_a && !xfer_gate_b && !shift_a && shift_b && !shift_last &&
               !reset_gate && !clamp_pulse && !line_busy && pixel_index == '0 && region == 2'd0;
    endfunction

    task automatic run_line(input int v);
        int lead, w, gap, post, h, mode, poke, exp_len;
        int k, busy_len, t_a, t_gar, t_gaf, t_gbr, t_gbf, t_pix, n_ga, run;
        int run_bad, quiet_bad, compl_bad, p2l_bad, overlap, idx_bad, rg_bad;
        int n_r, n_cp, cp_bad, cp_rise;
        bit in_read, pa, pga, pgb, pr, pcp;
        lead = (VEC[v][0] == 0) ? 1 : VEC[v][0];
        w    = (VEC[v][1] == 0) ? 1 : VEC[v][1];
        gap  = (VEC[v][2] == 0) ? 1 : VEC[v][2];
        post = (VEC[v][3] == 0) ? 1 : VEC[v][3];
        h    = (VEC[v][4] < 2)  ? 2 : VEC[v][4];
        mode = VEC[v][5];
        poke = VEC[v][6];
        exp_len = lead + 2 * w + gap + post + TOTAL * 2 * h;
        busy_len = 0; t_a = -1; t_gar = -1; t_gaf = -1; t_gbr = -1; t_gbf = -1; t_pix = -1;
        n_ga = 0; run = 0; run_bad = 0; quiet_bad = 0; compl_bad = 0; p2l_bad = 0;
        overlap = 0; idx_bad = 0; rg_bad = 0; n_r = 0; n_cp = 0; cp_bad = 0; cp_rise = 0;
        in_read = 0; pa = 0; pga = 0; pgb = 0; pr = 0; pcp = 0;

        @(negedge clk);
        cfg_lead = CNT_W'(VEC[v][0]); cfg_tg_width = CNT_W'(VEC[v][1]);
        cfg_tg_gap = CNT_W'(VEC[v][2]); cfg_post = CNT_W'(VEC[v][3]);
        cfg_half = CNT_W'(VEC[v][4]); clamp_mode = mode[0];
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk(line_busy && shift_a, "R2", "busy/shift_a one edge after start", int'(line_busy), 1);
        for (k = 0; k < 20000; k++) begin
            if (line_busy) busy_len++;
            if (shift_a && !pa && t_a < 0) t_a = k;
            if (xfer_gate_a && !pga) begin n_ga++; if (t_gar < 0) t_gar = k; end
            if (!xfer_gate_a && pga && t_gaf < 0) t_gaf = k;
            if (xfer_gate_b && !pgb && t_gbr < 0) t_gbr = k;
            if (!xfer_gate_b && pgb && t_gbf < 0) t_gbf = k;
            if (!in_read && t_gbf >= 0 && t_pix < 0 && !shift_a && pa) begin
                t_pix = k; in_read = 1; run = 1;
            end else if (in_read) begin
                if (shift_a != pa) begin
                    if (run != h) run_bad++;
                    run = 1;
                end else run++;
            end
            if (!line_busy) in_read = 0;
            if (line_busy && !in_read && (reset_gate || clamp_pulse || shift_last || !shift_a)) quiet_bad++;
            if (shift_b == shift_a) compl_bad++;
            if (in_read && shift_last != shift_b) p2l_bad++;
            if (!in_read && shift_last) p2l_bad++;
            if (xfer_gate_a && xfer_gate_b) overlap++;
            if (reset_gate) begin
                if (int'(pixel_index) != n_r || int'(region) != exp_region(n_r)) idx_bad++;
                if (!(in_read && !shift_a && (pa || k == t_pix))) rg_bad++;
                if (pr) rg_bad++;
                n_r++;
            end
            if (clamp_pulse) begin
                n_cp++;
                if (mode == 0 && !pr) cp_bad++;
                if (mode == 1 && region != 2'd1) cp_bad++;
                if (!pcp) cp_rise++;
            end
            pa = shift_a; pga = xfer_gate_a; pgb = xfer_gate_b; pr = reset_gate; pcp = clamp_pulse;
            if (!line_busy) break;
            @(negedge clk);
            line_start = (poke != 0 && (k == 300 || k == 20));
            #1 line_start = line_start;
        end
        line_start = 1'b0;
        chk(busy_len == exp_len, "R12", "line length", busy_len, exp_len);
        chk(t_gar - t_a == lead, "R2", "shift_a lead before gate a", t_gar - t_a, lead);
        chk(t_gaf - t_gar == w, "R3", "gate a width", t_gaf - t_gar, w);
        chk(t_gbr - t_gaf == gap, "R3", "gate gap", t_gbr - t_gaf, gap);
        chk(t_gbf - t_gbr == w && overlap == 0, "R3", "gate b width", t_gbf - t_gbr, w);
        chk(t_pix - t_gbf == post, "R5", "gate b fall to pixel 0", t_pix - t_gbf, post);
        chk(quiet_bad == 0, "R4", "transfer period quiet violations", quiet_bad, 0);
        chk(run_bad == 0 && compl_bad == 0 && p2l_bad == 0, "R6", "shift phase errors",
            run_bad + compl_bad + p2l_bad, 0);
        chk(n_r == TOTAL && rg_bad == 0, "R7", "reset pulses per line", n_r, TOTAL);
        chk(idx_bad == 0, "R10", "index/region mismatches", idx_bad, 0);
        if (mode == 0)
            chk(n_cp == TOTAL && cp_bad == 0, "R8", "per-pixel clamp count", n_cp, TOTAL);
        else
            chk(n_cp == N_OB * 2 * h && cp_bad == 0 && cp_rise == 1, "R9", "span clamp cycles",
                n_cp, N_OB * 2 * h);
        chk(n_ga == 1, "R11", "transfer sequences in one line", n_ga, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(idle_ok(), "R11", "idle after line end", int'(line_busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(idle_ok(), "R1", "outputs during reset", int'(shift_b), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(idle_ok(), "R1", "outputs after reset", int'(line_busy), 0);

        for (int v = 0; v < NVEC; v++) run_line(v);

        // Reset in the middle of a line returns to idle
        @(negedge clk);
        cfg_lead = 12'd5; cfg_tg_width = 12'd6; cfg_tg_gap = 12'd2; cfg_post = 12'd4; cfg_half = 12'd2;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (60) @(negedge clk);
        chk(line_busy == 1'b1, "R12", "busy mid line", int'(line_busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(idle_ok(), "R1", "outputs after mid-line reset", int'(line_busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(idle_ok(), "R1", "idle after reset release", int'(line_busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule